// File: doc/BRIEF.md
# Dual-Compare Event Timer with Selectable Counter Clear

This block is an 8-bit up-counter that advances once for every cycle in which an outside prescaler raises its count strobe. Two compare registers watch the count. When the count reaches either compare value, the matching status flag is raised. When the count wraps past its top value, an overflow flag is raised. A 2-bit clear-mode field chooses what returns the counter to zero: nothing, a match on compare A, a match on compare B, or a rising edge on an asynchronous clear pin. The pin is synchronised inside the block before it is used.

Software reaches the block through a small register bus. Writes take effect at the clock edge, and read data is combinational. The control register holds three interrupt enables, the clear mode and a 3-bit clock-select code. The block does not interpret the clock-select code; it only passes it to the prescaler. Each interrupt output is the AND of a status flag and its enable. A flag can only be cleared by the usual read-then-write-zero handshake.

Top module: `dual_cmp_timer`

## Requirements
- R1: Register offsets are control 0, status 1, compare A 2, compare B 3, counter 4. Control bits 2:0 appear unchanged on `clk_sel`.
- R2: After reset, every register reads 0 and all three interrupt outputs are low.
- R3: In a cycle with `count_en` high, the counter rises by one. It holds when `count_en` is low. A bus write to offset 4 loads the written value and takes priority over counting or clearing.
- R4: A count step from 0xFF wraps the counter to 0x00 and sets the overflow flag, which is status bit 0.
- R5: A count step taken while the counter equals compare A sets status bit 1. A count step taken while it equals compare B sets status bit 2.
- R6: Control bits 4:3 set the clear mode. Value 00 never clears the counter. Value 01 makes a compare-A step load 0 instead of incrementing. Value 10 does the same on a compare-B step.
- R7: With clear mode 11, a rising edge on `ext_clr_in` zeroes the counter at the third clock edge after the pin rises. The pin passes through a two-flop synchroniser and then an edge detector. In modes 00, 01 and 10 the pin has no effect.
- R8: `irq_cmb` is status bit 2 AND control bit 7. `irq_cma` is status bit 1 AND control bit 6. `irq_ovf` is status bit 0 AND control bit 5.
- R9: A status flag clears only when status is written with a 0 in that bit, and only if a status read since the last status write returned that bit as 1. Writing 1 to a status bit has no effect.
- R10: If a flag's set event and its clearing write fall in the same cycle, the flag stays at 1.
- R11: Status bits 7:3 read 0. Offsets 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| count_en | input | 1 | Count strobe from the prescaler |
| ext_clr_in | input | 1 | Asynchronous counter-clear pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status clearing) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| clk_sel | output | 3 | Clock-select code for the prescaler |
| irq_cmb | output | 1 | Compare-B interrupt request |
| irq_cma | output | 1 | Compare-A interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The assertions assume `bus_rd` and `bus_wr` are never high together at the status offset. They also assume that a counter write and a count strobe in the same cycle resolve in favour of the write. The stimulus therefore never issues a status read and a status write in the same cycle. It changes `ext_clr_in` only at least three cycles after its previous change, so each edge reaches the detector cleanly. All stimulus is driven between clock edges, so the synchroniser never sees a change on the sampling edge. A behavioural model in the bench predicts the read data, `clk_sel` and the three interrupt outputs, and compares them on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int SYNC_N  = 2;
    localparam int NFLAG   = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CMPA = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CMPB = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_PIN  = 2'b11
    } clr_mode_e;

    // Bit order fixed: 7 en_b, 6 en_a, 5 en_ovf, 4:3 mode, 2:0 clock select
    typedef struct packed {
        logic      en_b;
        logic      en_a;
        logic      en_ovf;
        clr_mode_e mode;
        logic [2:0] csel;
    } ctrl_t;

    // Status bit order: 2 cmb, 1 cma, 0 ovf
    typedef struct packed {
        logic cmb;
        logic cma;
        logic ovf;
    } flags_t;

    function automatic flags_t gate_irq(flags_t f, ctrl_t c);
        flags_t r;
        r.cmb = f.cmb & c.en_b;
        r.cma = f.cma & c.en_a;
        r.ovf = f.ovf & c.en_ovf;
        return r;
    endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = tmr_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], pin};
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R7: an edge pulse lasts one cycle
    p_edge_single_r7: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         count_en,
    input  clr_mode_e    mode,
    input  logic         pin_rise,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output logic [W-1:0] cnt,
    output flags_t       evt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic pin_clr, adv, hit_a, hit_b, clr_hit;

    assign pin_clr = pin_rise & (mode == CLR_PIN);
    assign adv     = count_en & ~load & ~pin_clr;
    assign hit_a   = adv & (cnt_q == cmp_a);
    assign hit_b   = adv & (cnt_q == cmp_b);
    assign clr_hit = ((mode == CLR_ON_A) & hit_a) | ((mode == CLR_ON_B) & hit_b);

    always_comb begin
        evt.cma = hit_a;
        evt.cmb = hit_b;
        evt.ovf = adv & ~clr_hit & (cnt_q == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (load)    cnt_q <= load_val;
        else if (pin_clr) cnt_q <= '0;
        else if (adv)     cnt_q <= clr_hit ? '0 : cnt_q + W'(1);
    end

    assign cnt = cnt_q;

    // R3: plain step adds one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr_hit) |=> cnt_q == $past(cnt_q) + W'(1));
    // R3: no strobe, no load, no pin clear keeps value
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !load && !pin_clr) |=> $stable(cnt_q));
    // R6: selected match returns to zero
    p_match_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> cnt_q == '0);
    // R7: pin edge in pin mode zeroes the count
    p_pin_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (pin_rise && mode == CLR_PIN && !load) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
    import tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_evt,
    input  logic   rd_stat,
    input  logic   wr_stat,
    input  flags_t wdata,
    output flags_t flags
);
    logic [NFLAG-1:0] flag_q, arm_q, wipe;

    always_comb begin
        for (int i = 0; i < NFLAG; i++)
            wipe[i] = wr_stat & ~wdata[i] & arm_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            arm_q  <= '0;
        end else begin
            flag_q <= set_evt | (flag_q & ~wipe);
            if (wr_stat)      arm_q <= '0;
            else if (rd_stat) arm_q <= flag_q;
        end
    end

    assign flags = flags_t'(flag_q);

    // R10: a set event always leaves the flag at 1
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        set_evt.ovf |=> flags.ovf);
    // R9: without a status write or set event, flags hold
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_stat && set_evt == '0) |=> $stable(flag_q));
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              count_en,
    input  logic              ext_clr_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [2:0]        clk_sel,
    output logic              irq_cmb,
    output logic              irq_cma,
    output logic              irq_ovf
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmpa_q, cmpb_q, cnt;
    flags_t           evt, flags, irq;
    logic             pin_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmpa_q <= '0;
            cmpb_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
            if (bus_addr == OFS_CMPA) cmpa_q <= bus_wdata;
            if (bus_addr == OFS_CMPB) cmpb_q <= bus_wdata;
        end
    end

    tmr_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .pin(ext_clr_in), .rise(pin_rise)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .count_en(count_en), .mode(ctrl_q.mode),
        .pin_rise(pin_rise), .load(bus_wr && bus_addr == OFS_CNT),
        .load_val(bus_wdata), .cmp_a(cmpa_q), .cmp_b(cmpb_q),
        .cnt(cnt), .evt(evt)
    );

    tmr_flags u_flags (
        .clk(clk), .rst(rst), .set_evt(evt),
        .rd_stat(bus_rd && bus_addr == OFS_STAT),
        .wr_stat(bus_wr && bus_addr == OFS_STAT),
        .wdata(flags_t'(bus_wdata[NFLAG-1:0])), .flags(flags)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_STAT: bus_rdata = {{(CNT_W-NFLAG){1'b0}}, flags};
            OFS_CMPA: bus_rdata = cmpa_q;
            OFS_CMPB: bus_rdata = cmpb_q;
            OFS_CNT:  bus_rdata = cnt;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = gate_irq(flags, ctrl_q);
    assign irq_cmb = irq.cmb;
    assign irq_cma = irq.cma;
    assign irq_ovf = irq.ovf;
    assign clk_sel = ctrl_q.csel;

    // R2: control register empty after reset
    p_reset_ctrl_r2: assert property (@(posedge clk)
        rst |=> ctrl_q == '0);
    // R4: a wrap step raises the overflow flag
    p_wrap_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (count_en && !bus_wr && cnt == 8'hFF && ctrl_q.mode == CLR_NONE) |=> flags.ovf);
endmodule

// File: tb/dual_cmp_timer_tb.sv
module dual_cmp_timer_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic count_en = 1'b0, ext_clr_in = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [2:0] clk_sel;
    logic irq_cmb, irq_cma, irq_ovf;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_cmp_timer dut_i (
        .clk(clk), .rst(rst), .count_en(count_en), .ext_clr_in(ext_clr_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
        .irq_cmb(irq_cmb), .irq_cma(irq_cma), .irq_ovf(irq_ovf)
    );

    // behavioural reference model
    logic [7:0] m_ctrl = 0, m_cmpa = 0, m_cmpb = 0, m_cnt = 0;
    logic [2:0] m_flag = 0, m_arm = 0;
    logic [2:0] m_sync = 0;
    bit started = 0;

    always @(posedge clk) begin
        logic edge_seen, pclr, adv, ha, hb, hit, ov, stw;
        logic [2:0] setv;
        logic [1:0] mode;
        if (rst) begin
            m_ctrl = 0; m_cmpa = 0; m_cmpb = 0; m_cnt = 0;
            m_flag = 0; m_arm = 0; m_sync = 0;
        end else begin
            mode = m_ctrl[4:3];
            edge_seen = m_sync[1] && !m_sync[2];
            pclr = edge_seen && mode == 2'd3;
            adv = count_en && !(bus_wr && bus_addr == 4) && !pclr;
            ha = adv && m_cnt == m_cmpa;
            hb = adv && m_cnt == m_cmpb;
            hit = (mode == 2'd1 && ha) || (mode == 2'd2 && hb);
            ov = adv && !hit && m_cnt == 8'hFF;
            setv = {hb, ha, ov};
            stw = bus_wr && bus_addr == 1;
            for (int i = 0; i < 3; i++)
                if (!setv[i] && stw && !bus_wdata[i] && m_arm[i]) m_flag[i] = 1'b0;
            if (stw) m_arm = 0;
            else if (bus_rd && bus_addr == 1) m_arm = m_flag;
            m_flag = m_flag | setv;
            if (bus_wr && bus_addr == 4) m_cnt = bus_wdata;
            else if (pclr) m_cnt = 0;
            else if (adv) m_cnt = hit ? 8'h00 : m_cnt + 8'h01;
            if (bus_wr && bus_addr == 0) m_ctrl = bus_wdata;
            if (bus_wr && bus_addr == 2) m_cmpa = bus_wdata;
            if (bus_wr && bus_addr == 3) m_cmpb = bus_wdata;
            m_sync = {m_sync[1:0], ext_clr_in};
        end
        started = 1;
    end

    function automatic logic [7:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return {5'b0, m_flag};
            3'd2: return m_cmpa;
            3'd3: return m_cmpb;
            3'd4: return m_cnt;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk($sformatf("R11 model rdata at offset %0d", bus_addr), bus_rdata, m_read(bus_addr));
            chk("R8 model irq_cmb", {7'b0, irq_cmb}, {7'b0, m_flag[2] & m_ctrl[7]});
            chk("R8 model irq_cma", {7'b0, irq_cma}, {7'b0, m_flag[1] & m_ctrl[6]});
            chk("R8 model irq_ovf", {7'b0, irq_ovf}, {7'b0, m_flag[0] & m_ctrl[5]});
            chk("R1 model clk_sel", {5'b0, clk_sel}, {5'b0, m_ctrl[2:0]});
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask
    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(); bus_wr = 0;
    endtask
    task automatic rd_expect(logic [2:0] a, logic [7:0] exp, string tag);
        bus_addr = a; bus_rd = 1; #1;
        chk(tag, bus_rdata, exp);
        cyc(); bus_rd = 0;
    endtask
    task automatic run(int n);
        count_en = 1; repeat (n) cyc(); count_en = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R2 reset state
        rd_expect(0, 8'h00, "R2 ctrl after reset");
        rd_expect(1, 8'h00, "R2 status after reset");
        rd_expect(4, 8'h00, "R2 counter after reset");
        chk("R2 irqs after reset", {5'b0, irq_cmb, irq_cma, irq_ovf}, 8'h00);

        // R3 counting and hold
        wr(2, 8'h80); wr(3, 8'h90);
        run(5);
        rd_expect(4, 8'h05, "R3 five steps");
        repeat (3) cyc();
        rd_expect(4, 8'h05, "R3 hold without strobe");
        wr(4, 8'h33);
        rd_expect(4, 8'h33, "R3 load by write");

        // R6 clear on compare A, R5 flag A
        wr(0, 8'h48); wr(4, 8'h00); wr(2, 8'h03);
        run(4);
        rd_expect(4, 8'h00, "R6 cleared at compare A");
        rd_expect(1, 8'h02, "R5 compare A flag");
        chk("R8 irq_cma with enable", {7'b0, irq_cma}, 8'h01);
        run(2);
        rd_expect(4, 8'h02, "R6 counts on after clear");
        wr(1, 8'h00);
        rd_expect(1, 8'h00, "R9 armed clear of flag A");

        // R6 clear on compare B; A matches without clearing
        wr(0, 8'h90); wr(2, 8'h01); wr(3, 8'h02); wr(4, 8'h00);
        run(3);
        rd_expect(4, 8'h00, "R6 cleared at compare B");
        rd_expect(1, 8'h06, "R5 both compare flags");
        chk("R8 irq_cmb enabled", {7'b0, irq_cmb}, 8'h01);
        chk("R8 irq_cma disabled", {7'b0, irq_cma}, 8'h00);
        wr(1, 8'h00);
        rd_expect(1, 8'h00, "R9 clear both flags");

        // R7 pin ignored in mode 00, then clears in mode 11
        wr(0, 8'h00); wr(2, 8'h80); wr(3, 8'h90); wr(4, 8'h40);
        ext_clr_in = 1; repeat (4) cyc(); ext_clr_in = 0; repeat (4) cyc();
        rd_expect(4, 8'h40, "R7 pin ignored in mode 00");
        wr(0, 8'h18);
        ext_clr_in = 1; repeat (2) cyc();
        rd_expect(4, 8'h40, "R7 not yet cleared after two edges");
        rd_expect(4, 8'h00, "R7 cleared at third edge");
        run(2);
        rd_expect(4, 8'h02, "R7 level alone does not clear");
        ext_clr_in = 0; repeat (4) cyc();

        // R4 overflow, R8 gating, R9 handshake
        wr(0, 8'h00); wr(2, 8'h10); wr(3, 8'h10); wr(4, 8'hFE);
        run(3);
        chk("R8 irq_ovf disabled", {7'b0, irq_ovf}, 8'h00);
        wr(1, 8'h00);
        rd_expect(1, 8'h01, "R9 unarmed write keeps flag");
        rd_expect(4, 8'h01, "R4 wrapped counter");
        wr(0, 8'h20);
        chk("R8 irq_ovf enabled", {7'b0, irq_ovf}, 8'h01);
        wr(1, 8'hFF);
        rd_expect(1, 8'h01, "R9 writing ones keeps flag");
        wr(1, 8'h00);
        rd_expect(1, 8'h00, "R9 armed write clears");
        chk("R8 irq_ovf drops", {7'b0, irq_ovf}, 8'h00);
        wr(1, 8'h07);
        rd_expect(1, 8'h00, "R9 writing ones cannot set");

        // R10 set beats clear
        wr(4, 8'hFF); run(1);
        rd_expect(1, 8'h01, "R4 overflow flag set");
        wr(4, 8'hFF);
        count_en = 1; wr(1, 8'h00); count_en = 0;
        rd_expect(1, 8'h01, "R10 set wins over clear");
        rd_expect(4, 8'h00, "R10 counter wrapped");

        // R11 unmapped offsets, R1 clock select
        wr(6, 8'hAA);
        rd_expect(6, 8'h00, "R11 unmapped reads zero");
        rd_expect(0, 8'h20, "R11 unmapped write ignored");
        wr(0, 8'h25);
        chk("R1 clk_sel follows control", {5'b0, clk_sel}, 8'h05);
        repeat (2) cyc();
        finish_run();
    end
endmodule